// File: doc/BRIEF.md
# Double-Word Integer Execution Unit

This unit executes 32-bit two's-complement arithmetic for a processor whose registers are 16 bits wide. A request selects an operation code and supplies one or two operands as full 32-bit words. The unit returns the result split across two 16-bit halves: A holds the upper half and B the lower half. It also maintains an overflow flag and a carry flag that only ever gets set, and it reports a skip count of 0, 1 or 2. The surrounding sequencer adds that count to its return address.

Addition, subtraction (forward and reversed), negation, increment, decrement, compare, memory-style increment/decrement-with-skip and a self-test each finish in one cycle. Multiplication and division (forward and reversed) run in iterative datapaths, one bit per clock, behind a start/busy/done handshake. Both saturate to the largest positive value whenever their result cannot be represented. Fetching operands and writing memory are left to the caller.

Top module: `dint_exec`

## Requirements
- R1: After reset, A, B, overflow, carry, skip, revision and status outputs are all zero and busy/done are low. For single-cycle operations done_o pulses for exactly one cycle, set by the clock edge that samples start_i. A always carries result bits 31:16 and B carries bits 15:0.
- R2: Add (code 1) returns a+b. It sets carry when the unsigned sum wraps, and it sets overflow exactly when the signed sum falls outside the 32-bit range.
- R3: Subtract (code 7) returns a-b, and reversed subtract (code 12) returns b-a. Carry is set when the unsigned minuend is below the subtrahend. Overflow is set exactly when the signed difference is out of range.
- R4: Carry is only ever ORed with the new carry condition, by add, subtract, negate, increment and decrement. Only reset clears it.
- R5: Negate (code 3) returns -a. Overflow is set only for a=0x80000000, and carry is set when a is zero.
- R6: Increment (code 8) returns a+1. It overflows when the result is 0x80000000 and sets carry when the result is 0. Decrement (code 9) returns a-1. It overflows when the result is 0x7FFFFFFF and sets carry when the result is all ones.
- R7: Compare (code 4) returns a as the result. Skip is 0 when a=b, 1 when a<b signed and 2 when a>b signed. Overflow and carry are unchanged.
- R8: Memory increment (code 10) and memory decrement (code 11) return a+1 and a-1. Skip is 1 when that value is zero and 0 otherwise. Neither flag changes.
- R9: Multiply (code 2) returns the signed product when it fits in 32 bits, with overflow cleared. Otherwise it returns 0x7FFFFFFF with overflow set. Skip is 0 and carry is unchanged.
- R10: Divide (code 5) returns a/b truncated toward zero, and reversed divide (code 6) returns b/a. A zero divisor, or 0x80000000 divided by -1, gives 0x7FFFFFFF with overflow set. Otherwise overflow is cleared. Skip is 0 and carry is unchanged.
- R11: Multiply and divide raise busy_o after the edge that samples start_i. The result and done_o appear W+1 edges after that edge, with busy_o falling on the same edge. A start_i seen while busy is ignored.
- R12: Self-test (code 0) keeps A, sets B to 0377 octal, sets rev_o to 2 and stat_o to 0102077 octal, and returns skip 1. Flags are unchanged.
- R13: Codes 13 to 15 pulse done_o and change no result, flag, skip, revision or status output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request strobe, sampled when not busy |
| op_i | input | 4 | Operation code |
| opa_i | input | W | First operand |
| opb_i | input | W | Second operand |
| busy_o | output | 1 | Iterative operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| res_a_o | output | W/2 | Result upper half |
| res_b_o | output | W/2 | Result lower half |
| ovf_o | output | 1 | Overflow flag |
| carry_o | output | 1 | Sticky carry/borrow flag |
| skip_o | output | 2 | Return-address skip count |
| rev_o | output | 16 | Self-test revision |
| stat_o | output | 16 | Self-test status word |

## Verification
Single-cycle operations register their result on the edge that samples start_i, so the bench reads them at the following falling edge. Multiply and divide take the sampling edge plus W+1 more. The bench counts falling edges from the request and expects done_o at count 1 or count W+2, and it reads results only at that point. It sweeps a table of corner operands (zero, ±1, ±2, the two extremes and their neighbours, mixed-width values) through every operation pair. It also keeps a model of the sticky carry, and it injects a request while busy and an undefined code, then checks that the outputs are left unchanged.

// File: rtl/dint_pkg.sv
package dint_pkg;
  typedef enum logic [3:0] {
    OP_TEST = 4'd0,  OP_ADD  = 4'd1,  OP_MUL  = 4'd2,  OP_NEG  = 4'd3,
    OP_CMP  = 4'd4,  OP_DIV  = 4'd5,  OP_DIVR = 4'd6,  OP_SUB  = 4'd7,
    OP_INC  = 4'd8,  OP_DEC  = 4'd9,  OP_MINC = 4'd10, OP_MDEC = 4'd11,
    OP_SUBR = 4'd12
  } op_e;

  typedef struct packed {
    logic       ovf_we;
    logic       ovf;
    logic       cy_set;
    logic       skip_we;
    logic [1:0] skip;
    logic       test;
  } fx_t;

  localparam logic [15:0] ST_B_WORD = 16'o377;
  localparam logic [15:0] ST_STAT   = 16'o102077;
  localparam logic [15:0] ST_REV    = 16'd2;
endpackage

// File: rtl/dint_basic.sv
module dint_basic
  import dint_pkg::*;
#(
  parameter int W = 32
) (
  input  op_e          op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] prev_i,
  output logic [W-1:0] res_o,
  output fx_t          fx_o
);
  localparam int HW = W / 2;
  localparam int MSB = W - 1;
  localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] MAXV = ~MINV;
  localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] sum, dif, negv, incv, decv, sx, sy;
  logic [HW-1:0] st_b;

  assign st_b = HW'(ST_B_WORD);
  assign sx   = (op_i == OP_SUBR) ? b_i : a_i;
  assign sy   = (op_i == OP_SUBR) ? a_i : b_i;
  assign sum  = a_i + b_i;
  assign dif  = sx - sy;
  assign negv = ~a_i + ONE;
  assign incv = a_i + ONE;
  assign decv = a_i - ONE;

  always_comb begin
    res_o = prev_i;
    fx_o  = '0;
    case (op_i)
      OP_ADD: begin
        res_o       = sum;
        fx_o.ovf_we = 1'b1;
        fx_o.ovf    = ~(a_i[MSB] ^ b_i[MSB]) & (a_i[MSB] ^ sum[MSB]);
        fx_o.cy_set = sum < a_i;
        fx_o.skip_we = 1'b1;
      end
      OP_SUB, OP_SUBR: begin
        res_o       = dif;
        fx_o.ovf_we = 1'b1;
        fx_o.ovf    = (sx[MSB] ^ sy[MSB]) & (sx[MSB] ^ dif[MSB]);
        fx_o.cy_set = sx < sy;
        fx_o.skip_we = 1'b1;
      end
      OP_NEG: begin
        res_o       = negv;
        fx_o.ovf_we = 1'b1;
        fx_o.ovf    = a_i == MINV;
        fx_o.cy_set = a_i == '0;
        fx_o.skip_we = 1'b1;
      end
      OP_INC: begin
        res_o       = incv;
        fx_o.ovf_we = 1'b1;
        fx_o.ovf    = incv == MINV;
        fx_o.cy_set = incv == '0;
        fx_o.skip_we = 1'b1;
      end
      OP_DEC: begin
        res_o       = decv;
        fx_o.ovf_we = 1'b1;
        fx_o.ovf    = decv == MAXV;
        fx_o.cy_set = &decv;
        fx_o.skip_we = 1'b1;
      end
      OP_CMP: begin
        res_o        = a_i;
        fx_o.skip_we = 1'b1;
        if ($signed(a_i) < $signed(b_i))      fx_o.skip = 2'd1;
        else if ($signed(a_i) > $signed(b_i)) fx_o.skip = 2'd2;
      end
      OP_MINC: begin
        res_o        = incv;
        fx_o.skip_we = 1'b1;
        fx_o.skip    = {1'b0, incv == '0};
      end
      OP_MDEC: begin
        res_o        = decv;
        fx_o.skip_we = 1'b1;
        fx_o.skip    = {1'b0, decv == '0};
      end
      OP_TEST: begin
        res_o        = {prev_i[W-1:HW], st_b};
        fx_o.skip_we = 1'b1;
        fx_o.skip    = 2'd1;
        fx_o.test    = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/dint_mul.sv
module dint_mul #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         go_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         done_o,
  output logic [W-1:0] res_o,
  output logic         ovf_o
);
  localparam int MSB = W - 1;
  localparam int CW  = $clog2(W);
  localparam logic [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};

  logic [W-1:0]  hi_q, lo_q, ma_q;
  logic          neg_q, run_q;
  logic [CW-1:0] cnt_q;
  logic [W:0]    step_sum;

  assign step_sum = {1'b0, hi_q} + (lo_q[0] ? {1'b0, ma_q} : '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q <= '0; lo_q <= '0; ma_q <= '0;
      neg_q <= 1'b0; run_q <= 1'b0; cnt_q <= '0; done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (go_i) begin
        ma_q  <= a_i[MSB] ? -a_i : a_i;
        lo_q  <= b_i[MSB] ? -b_i : b_i;
        hi_q  <= '0;
        neg_q <= a_i[MSB] ^ b_i[MSB];
        cnt_q <= '0;
        run_q <= 1'b1;
      end else if (run_q) begin
        hi_q <= step_sum[W:1];
        lo_q <= {step_sum[0], lo_q[W-1:1]};
        if (cnt_q == CW'(W - 1)) begin
          run_q  <= 1'b0;
          done_o <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  // negative results may reach magnitude 2^(W-1), positive ones one less
  assign ovf_o = neg_q ? ((|hi_q) | (lo_q[MSB] & (|lo_q[W-2:0])))
                       : ((|hi_q) | lo_q[MSB]);
  assign res_o = ovf_o ? MAXV : (neg_q ? -lo_q : lo_q);
endmodule

// File: rtl/dint_div.sv
module dint_div #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         go_i,
  input  logic [W-1:0] dvd_i,
  input  logic [W-1:0] dvs_i,
  output logic         done_o,
  output logic [W-1:0] res_o,
  output logic         ovf_o
);
  localparam int MSB = W - 1;
  localparam int CW  = $clog2(W);
  localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] MAXV = ~MINV;

  logic [W-1:0]  quo_q, rem_q, dm_q;
  logic          neg_q, sat_q, run_q;
  logic [CW-1:0] cnt_q;
  logic [W:0]    shifted, trial;

  assign shifted = {rem_q, quo_q[MSB]};
  assign trial   = shifted - {1'b0, dm_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      quo_q <= '0; rem_q <= '0; dm_q <= '0;
      neg_q <= 1'b0; sat_q <= 1'b0; run_q <= 1'b0; cnt_q <= '0; done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (go_i) begin
        quo_q <= dvd_i[MSB] ? -dvd_i : dvd_i;
        dm_q  <= dvs_i[MSB] ? -dvs_i : dvs_i;
        rem_q <= '0;
        neg_q <= dvd_i[MSB] ^ dvs_i[MSB];
        sat_q <= (dvs_i == '0) || ((dvd_i == MINV) && (&dvs_i));
        cnt_q <= '0;
        run_q <= 1'b1;
      end else if (run_q) begin
        if (!trial[W]) begin
          rem_q <= trial[W-1:0];
          quo_q <= {quo_q[W-2:0], 1'b1};
        end else begin
          rem_q <= shifted[W-1:0];
          quo_q <= {quo_q[W-2:0], 1'b0};
        end
        if (cnt_q == CW'(W - 1)) begin
          run_q  <= 1'b0;
          done_o <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign ovf_o = sat_q;
  assign res_o = sat_q ? MAXV : (neg_q ? -quo_q : quo_q);
endmodule

// File: rtl/dint_exec.sv
module dint_exec
  import dint_pkg::*;
#(
  parameter int W = 32
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [3:0]     op_i,
  input  logic [W-1:0]   opa_i,
  input  logic [W-1:0]   opb_i,
  output logic           busy_o,
  output logic           done_o,
  output logic [W/2-1:0] res_a_o,
  output logic [W/2-1:0] res_b_o,
  output logic           ovf_o,
  output logic           carry_o,
  output logic [1:0]     skip_o,
  output logic [15:0]    rev_o,
  output logic [15:0]    stat_o
);
  localparam int HW = W / 2;

  typedef enum logic {S_IDLE, S_WAIT} st_e;

  st_e          st_q;
  op_e          op;
  logic [W-1:0] res_q, b_res, m_res, d_res, dvd, dvs;
  fx_t          fx;
  logic         is_long, take, mul_go, div_go, mul_sel_q;
  logic         m_done, m_ovf, d_done, d_ovf;

  assign op      = op_e'(op_i);
  assign take    = start_i && (st_q == S_IDLE);
  assign is_long = (op == OP_MUL) || (op == OP_DIV) || (op == OP_DIVR);
  assign mul_go  = take && (op == OP_MUL);
  assign div_go  = take && ((op == OP_DIV) || (op == OP_DIVR));
  assign dvd     = (op == OP_DIVR) ? opb_i : opa_i;
  assign dvs     = (op == OP_DIVR) ? opa_i : opb_i;

  dint_basic #(.W(W)) u_basic (
    .op_i(op), .a_i(opa_i), .b_i(opb_i), .prev_i(res_q), .res_o(b_res), .fx_o(fx)
  );

  dint_mul #(.W(W)) u_mul (
    .clk_i(clk_i), .rst_ni(rst_ni), .go_i(mul_go), .a_i(opa_i), .b_i(opb_i),
    .done_o(m_done), .res_o(m_res), .ovf_o(m_ovf)
  );

  dint_div #(.W(W)) u_div (
    .clk_i(clk_i), .rst_ni(rst_ni), .go_i(div_go), .dvd_i(dvd), .dvs_i(dvs),
    .done_o(d_done), .res_o(d_res), .ovf_o(d_ovf)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= S_IDLE; res_q <= '0; ovf_o <= 1'b0; carry_o <= 1'b0;
      skip_o <= '0; rev_o <= '0; stat_o <= '0; done_o <= 1'b0; mul_sel_q <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (st_q)
        S_IDLE: if (start_i) begin
          if (is_long) begin
            st_q      <= S_WAIT;
            mul_sel_q <= (op == OP_MUL);
          end else begin
            res_q  <= b_res;
            done_o <= 1'b1;
            if (fx.ovf_we)  ovf_o   <= fx.ovf;
            if (fx.cy_set)  carry_o <= 1'b1;
            if (fx.skip_we) skip_o  <= fx.skip;
            if (fx.test) begin
              rev_o  <= ST_REV;
              stat_o <= ST_STAT;
            end
          end
        end
        S_WAIT: if (m_done || d_done) begin
          res_q  <= mul_sel_q ? m_res : d_res;
          ovf_o  <= mul_sel_q ? m_ovf : d_ovf;
          skip_o <= 2'd0;
          done_o <= 1'b1;
          st_q   <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o  = (st_q == S_WAIT);
  assign res_a_o = res_q[W-1:HW];
  assign res_b_o = res_q[HW-1:0];
endmodule

// File: rtl/dint_exec_chk.sv
module dint_exec_chk #(
  parameter int W = 32
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           start_i,
  input logic [3:0]     op_i,
  input logic           busy_o,
  input logic           done_o,
  input logic [W/2-1:0] res_a_o,
  input logic [W/2-1:0] res_b_o,
  input logic           ovf_o,
  input logic           carry_o,
  input logic [1:0]     skip_o
);
  localparam logic [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};

  logic long_req;
  assign long_req = start_i && !busy_o && (op_i == 4'd2 || op_i == 4'd5 || op_i == 4'd6);

  a_r4_carry_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    carry_o |=> carry_o);
  a_r1_done_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r11_long_goes_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    long_req |=> busy_o);
  a_r11_busy_end_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);
  a_r11_done_not_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  a_r10_saturate_on_ovf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(busy_o) && ovf_o) |-> ({res_a_o, res_b_o} == MAXV));
  a_r7_skip_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    skip_o != 2'd3);
  a_r11_hold_while_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> ($stable(res_a_o) && $stable(res_b_o) && $stable(skip_o)));
endmodule

bind dint_exec dint_exec_chk #(.W(W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .op_i(op_i),
  .busy_o(busy_o), .done_o(done_o), .res_a_o(res_a_o), .res_b_o(res_b_o),
  .ovf_o(ovf_o), .carry_o(carry_o), .skip_o(skip_o)
);

// File: tb/dint_exec_tb.sv
module dint_exec_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32;
  localparam longint MAXI = 64'sd2147483647;
  localparam longint MINI = -64'sd2147483648;

  logic clk = 1'b0, rst_ni = 1'b0, start_i = 1'b0;
  logic [3:0] op_i = '0;
  logic [31:0] opa_i = '0, opb_i = '0;
  logic busy_o, done_o, ovf_o, carry_o;
  logic [15:0] res_a_o, res_b_o, rev_o, stat_o;
  logic [1:0] skip_o;

  int checks = 0, errors = 0;
  logic [31:0] m_res = '0;
  logic m_ovf = 1'b0, m_cy = 1'b0;
  logic [1:0] m_skip = '0;
  logic [15:0] m_rev = '0, m_stat = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dint_exec #(.W(W)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .op_i(op_i),
    .opa_i(opa_i), .opb_i(opb_i), .busy_o(busy_o), .done_o(done_o),
    .res_a_o(res_a_o), .res_b_o(res_b_o), .ovf_o(ovf_o), .carry_o(carry_o),
    .skip_o(skip_o), .rev_o(rev_o), .stat_o(stat_o)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string tag(logic [3:0] op);
    case (op)
      4'd0: return "R12";  4'd1: return "R2";  4'd2: return "R9";
      4'd3: return "R5";   4'd4: return "R7";  4'd5, 4'd6: return "R10";
      4'd7, 4'd12: return "R3"; 4'd8, 4'd9: return "R6";
      4'd10, 4'd11: return "R8"; default: return "R13";
    endcase
  endfunction

  task automatic model(logic [3:0] op, logic [31:0] a, logic [31:0] b);
    longint sa = longint'($signed(a));
    longint sb = longint'($signed(b));
    longint r;
    case (op)
      4'd1: begin r = sa + sb; m_res = a + b;
        m_cy |= ({1'b0, a} + {1'b0, b}) > 33'h0_FFFF_FFFF;
        m_ovf = r > MAXI || r < MINI; m_skip = 0; end
      4'd7, 4'd12: begin
        if (op == 4'd12) begin r = sb - sa; m_res = b - a; m_cy |= b < a; end
        else begin r = sa - sb; m_res = a - b; m_cy |= a < b; end
        m_ovf = r > MAXI || r < MINI; m_skip = 0; end
      4'd3: begin m_res = 32'(-sa); m_ovf = (sa == MINI); m_cy |= (a == 0); m_skip = 0; end
      4'd8: begin m_res = a + 1; m_ovf = (sa == MAXI); m_cy |= (a == '1); m_skip = 0; end
      4'd9: begin m_res = a - 1; m_ovf = (sa == MINI); m_cy |= (a == 0); m_skip = 0; end
      4'd4: begin m_res = a; m_skip = (sa == sb) ? 2'd0 : (sa < sb) ? 2'd1 : 2'd2; end
      4'd10: begin m_res = a + 1; m_skip = (a == '1) ? 2'd1 : 2'd0; end
      4'd11: begin m_res = a - 1; m_skip = (a == 1) ? 2'd1 : 2'd0; end
      4'd2: begin r = sa * sb; m_ovf = r > MAXI || r < MINI;
        m_res = m_ovf ? 32'h7FFF_FFFF : 32'(r); m_skip = 0; end
      4'd5, 4'd6: begin
        longint n = (op == 4'd6) ? sb : sa;
        longint d = (op == 4'd6) ? sa : sb;
        m_ovf = (d == 0) || (n == MINI && d == -1);
        m_res = m_ovf ? 32'h7FFF_FFFF : 32'(n / d); m_skip = 0; end
      4'd0: begin m_res = {m_res[31:16], 16'o377}; m_skip = 1;
        m_rev = 16'd2; m_stat = 16'o102077; end
      default: ;
    endcase
  endtask

  task automatic compare_all(string req);
    chk({req, " result"}, {res_a_o, res_b_o}, m_res);
    chk({req, " ovf"}, 32'(ovf_o), 32'(m_ovf));
    chk({req, " carry R4"}, 32'(carry_o), 32'(m_cy));
    chk({req, " skip"}, 32'(skip_o), 32'(m_skip));
  endtask

  task automatic run(logic [3:0] op, logic [31:0] a, logic [31:0] b);
    bit lng = (op == 4'd2 || op == 4'd5 || op == 4'd6);
    int n = 0;
    string t = tag(op);
    model(op, a, b);
    @(negedge clk);
    start_i = 1'b1; op_i = op; opa_i = a; opb_i = b;
    do begin
      @(negedge clk);
      start_i = 1'b0;
      n++;
      if (n == 1 && lng) chk("R11 busy raised", 32'(busy_o), 32'd1);
    end while (!done_o && n < 60);
    chk({t, " R11 latency"}, n, lng ? W + 2 : 1);
    compare_all(t);
    if (op == 4'd0) begin
      chk("R12 rev", 32'(rev_o), 32'(m_rev));
      chk("R12 stat", 32'(stat_o), 32'(m_stat));
    end
  endtask

  logic [31:0] vals [12] = '{32'h0, 32'h1, 32'h2, 32'hFFFF_FFFF, 32'hFFFF_FFFE,
    32'h7FFF_FFFF, 32'h8000_0000, 32'h8000_0001, 32'h7, 32'hFFFF_FFF9,
    32'h0001_2345, 32'h0001_0000};

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R11 watchdog actual=hang expected=completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1;
    chk("R1 reset res", {res_a_o, res_b_o}, 32'h0);
    chk("R1 reset flags", {28'h0, ovf_o, carry_o, skip_o}, 32'h0);
    chk("R1 reset idle", {30'h0, busy_o, done_o}, 32'h0);
    chk("R1 reset rev/stat", {rev_o, stat_o}, 32'h0);
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    run(4'd0, 32'h0, 32'h0);            // R12 self-test with A=0
    run(4'd1, 32'h1234_0000, 32'h0);     // load A
    run(4'd0, 32'h0, 32'h0);            // R12 keeps A
    @(negedge clk);
    chk("R1 done one cycle", 32'(done_o), 32'd0);

    for (int i = 0; i < 12; i++) begin
      run(4'd3, vals[i], 32'h0);
      run(4'd8, vals[i], 32'h0);
      run(4'd9, vals[i], 32'h0);
      run(4'd10, vals[i], 32'h0);
      run(4'd11, vals[i], 32'h0);
      for (int j = 0; j < 12; j++) begin
        run(4'd1, vals[i], vals[j]);
        run(4'd7, vals[i], vals[j]);
        run(4'd12, vals[i], vals[j]);
        run(4'd4, vals[i], vals[j]);
        run(4'd2, vals[i], vals[j]);
        run(4'd5, vals[i], vals[j]);
        run(4'd6, vals[i], vals[j]);
      end
    end

    // R13 undefined codes leave state untouched
    run(4'd1, 32'h0000_0005, 32'h0000_0003);
    for (int c = 13; c < 16; c++) run(4'(c), 32'hDEAD_BEEF, 32'h1);
    @(negedge clk);
    compare_all("R13 after");

    // R11 start while busy is ignored
    model(4'd2, 32'h0000_0100, 32'h0000_0100);
    @(negedge clk);
    start_i = 1'b1; op_i = 4'd2; opa_i = 32'h100; opb_i = 32'h100;
    @(negedge clk);
    start_i = 1'b0;
    repeat (4) @(negedge clk);
    start_i = 1'b1; op_i = 4'd1; opa_i = 32'h1; opb_i = 32'h1;
    @(negedge clk);
    start_i = 1'b0;
    begin
      int n = 0;
      while (!done_o && n < 60) begin @(negedge clk); n++; end
    end
    compare_all("R11 busy start ignored");
    @(negedge clk);
    chk("R11 no extra done", 32'(done_o), 32'd0);
    chk("R11 result held", {res_a_o, res_b_o}, m_res);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule